// File: doc/BRIEF.md
# Periodic Compare-Match Timer Channel

This block is one channel of a general-purpose timer. A 16-bit up-counter advances on ticks from a prescaler that divides the peripheral clock by 1, 4, 16 or 64. When a tick finds the counter equal to compare register A, the channel raises a match flag. If the control register selects it, the counter also returns to zero on that same tick. This gives a periodic interrupt every (compare + 1) prescaled ticks.

Software reaches the channel through a simple synchronous register bus. Each access has an address, a write strobe, a read strobe and 16-bit write data. Read data comes back registered, one cycle after the read strobe. Byte registers use the low eight data bits. The counter and compare A are halfword registers.

Starting and stopping the counter happens through a start register shared by several channels. It sits outside the channel's own window, at offset `RUN_OFFSET`. This channel owns only bit `RUN_BIT` of it.

Two small state machines carry the control.

The run machine has two states:
- `RUN_IDLE`: the counter and the prescaler are held.
- `RUN_ACTIVE`: counting.
- Transition *start* (`RUN_IDLE` to `RUN_ACTIVE`): a write to the start register with the owned bit set.
- Transition *stop* (`RUN_ACTIVE` to `RUN_IDLE`): a write to the start register with that bit clear.

The flag machine has three states:
- `FLG_CLEAR`: no event is outstanding.
- `FLG_PENDING`: an event is flagged but software has not yet seen it.
- `FLG_ARMED`: an event is flagged and software has read the status register.
- Transition *match* (`FLG_CLEAR` to `FLG_PENDING`).
- Transition *observe* (`FLG_PENDING` to `FLG_ARMED`): a status read.
- Transition *acknowledge* (`FLG_ARMED` to `FLG_CLEAR`): a status write with bit 0 at zero.
- Transition *re-trigger* (`FLG_ARMED` to `FLG_PENDING`): the same write lands in the cycle of a new match.

Top module: `pct_channel`

## Requirements
- R1: Reset (active-low `rst_n`) brings every register to zero, the run state to idle and `irq_out` low. Reads of any register then return 0.
- R2: The channel registers sit at fixed byte offsets, and each reads back what was last written: control at 0, mode at 1, I/O control at 2, interrupt enable at 4, status at 5, counter at 6 and compare A at 8. Byte registers take `bus_wdata[7:0]`; counter and compare A take all 16 bits. `bus_rdata` presents the addressed value after the clock edge that samples `bus_rd`, and is 0 in cycles without a read.
- R3: A write to `RUN_OFFSET` sets the run state from bit `RUN_BIT` and ignores all other bits. A read there returns only that bit in its position. While stopped, the counter holds its value.
- R4: Control bits 2:0 select the tick rate: 0 gives every cycle, 1 gives every 4th, 2 gives every 16th, and 3 to 7 give every 64th running cycle. The prescaler restarts from zero each time the channel is stopped, so the first tick after a start comes after a full division.
- R5: On a tick with counter equal to compare A, the match flag (status bit 0) sets. If control bits 6:5 are 01, the counter becomes 0 on that tick, so the period is compare+1 ticks. If they are 00, it keeps counting and wraps modulo 2^16.
- R6: `irq_out` is high exactly when the match flag is set and interrupt-enable bit 0 is 1. It stays high until the flag is cleared.
- R7: A status write with bit 0 = 0 clears the flag only if the status register was read while the flag was set. A status write with bit 0 = 1 never changes the flag.
- R8: If a clearing status write and a new match fall in the same cycle, the flag stays set. A fresh status read is then needed before the next clear.
- R9: A counter write in a cycle where a tick would also advance the counter stores the written value; the tick's step is lost.
- R10: Mode and I/O control registers are stored and read back but have no effect on counting, flagging or the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | CNT_W | Write data (low byte for byte registers) |
| bus_rdata | output | CNT_W | Registered read data, valid the cycle after `bus_rd` |
| irq_out | output | 1 | Compare-A match interrupt |

## Verification
The assertions check these on every cycle:
- a stopped counter never moves and the prescaler never ticks while stopped;
- every match sets the flag, and in clear-on-match mode it zeroes the counter;
- an unread flag can never drop, and the interrupt never rises without its enable;
- a counter write always lands with its exact value.

Only the bench's scenarios can show the rest:
- the exact period in ticks under two prescaler rates;
- the wrap-free continue mode;
- the read-then-write acknowledge order;
- the same-cycle race between acknowledge and a new match;
- the isolation of the shared start register from foreign bits.

// File: rtl/pct_pkg.sv
package pct_pkg;

    localparam int BYTE_W    = 8;

    // Byte offsets inside the channel window
    localparam int OFF_CTRL  = 0;
    localparam int OFF_MODE  = 1;
    localparam int OFF_IOCTL = 2;
    localparam int OFF_IEN   = 4;
    localparam int OFF_STAT  = 5;
    localparam int OFF_CNT   = 6;
    localparam int OFF_CMPA  = 8;

    // Clear-source field values (control bits 6:5)
    localparam logic [1:0] CLR_NONE = 2'b00;
    localparam logic [1:0] CLR_CMPA = 2'b01;

    typedef enum logic {
        RUN_IDLE,
        RUN_ACTIVE
    } run_state_e;

    typedef enum logic [1:0] {
        FLG_CLEAR,
        FLG_PENDING,
        FLG_ARMED
    } flag_state_e;

endpackage

// File: rtl/pct_run_ctl.sv
module pct_run_ctl
    import pct_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic start_val,
    output logic running
);

    run_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RUN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_IDLE:   if (start_wr && start_val)  state_d = RUN_ACTIVE;  // start
            RUN_ACTIVE: if (start_wr && !start_val) state_d = RUN_IDLE;    // stop
            default:    state_d = RUN_IDLE;
        endcase
    end

    always_comb begin
        running = (state_q == RUN_ACTIVE);
    end

endmodule

// File: rtl/pct_prescaler.sv
module pct_prescaler #(
    parameter int PS_W  = 6,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    // Rates are powers of four: 1, 4, 16, ... up to 2**PS_W
    localparam int NUM_RATES = PS_W / 2 + 1;

    logic [PS_W-1:0] mask_tbl [NUM_RATES];
    logic [PS_W-1:0] mask;
    logic [PS_W-1:0] pc_q;

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        assign mask_tbl[g] = PS_W'((1 << (2 * g)) - 1);
    end

    // Selections beyond the table fall back to the slowest rate
    always_comb begin
        mask = mask_tbl[NUM_RATES-1];
        for (int i = 0; i < NUM_RATES; i++) begin
            if (int'(sel) == i) mask = mask_tbl[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pc_q <= '0;
        else if (!running) pc_q <= '0;
        else               pc_q <= pc_q + PS_W'(1);
    end

    assign tick = running && ((pc_q & mask) == mask);

endmodule

// File: rtl/pct_counter.sv
module pct_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr_en,
    input  logic [CNT_W-1:0] cmp,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] cnt,
    output logic             match_evt
);

    logic [CNT_W-1:0] cnt_q;

    // A software write displaces the tick, including its match
    assign match_evt = tick && !wr_en && (cnt_q == cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_en) begin
            cnt_q <= wr_val;
        end else if (tick) begin
            if (match_evt && clr_en) cnt_q <= '0;
            else                     cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/pct_flag_fsm.sv
module pct_flag_fsm
    import pct_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match_evt,
    input  logic stat_rd,
    input  logic stat_wr,
    input  logic stat_wbit,
    output logic flag,
    output logic armed
);

    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR: begin
                if (match_evt) state_d = FLG_PENDING;              // match
            end
            FLG_PENDING: begin
                if (stat_rd) state_d = FLG_ARMED;                  // observe
            end
            FLG_ARMED: begin
                if (stat_wr && !stat_wbit) begin
                    state_d = match_evt ? FLG_PENDING              // re-trigger
                                        : FLG_CLEAR;               // acknowledge
                end
            end
            default: state_d = FLG_CLEAR;
        endcase
    end

    always_comb begin
        flag  = (state_q != FLG_CLEAR);
        armed = (state_q == FLG_ARMED);
    end

endmodule

// File: rtl/pct_channel.sv
module pct_channel
    import pct_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int CNT_W      = 16,
    parameter int PS_W       = 6,
    parameter int RUN_OFFSET = 'h40,
    parameter int RUN_BIT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq_out
);

    localparam int SEL_W = 3;

    // Address decode
    logic sel_ctrl, sel_mode, sel_ioc, sel_ien, sel_stat, sel_cnt, sel_cmp, sel_run;
    assign sel_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
    assign sel_mode = (bus_addr == ADDR_W'(OFF_MODE));
    assign sel_ioc  = (bus_addr == ADDR_W'(OFF_IOCTL));
    assign sel_ien  = (bus_addr == ADDR_W'(OFF_IEN));
    assign sel_stat = (bus_addr == ADDR_W'(OFF_STAT));
    assign sel_cnt  = (bus_addr == ADDR_W'(OFF_CNT));
    assign sel_cmp  = (bus_addr == ADDR_W'(OFF_CMPA));
    assign sel_run  = (bus_addr == ADDR_W'(RUN_OFFSET));

    // Byte and halfword registers
    logic [BYTE_W-1:0] ctrl_q, mode_q, ioc_q, ien_q;
    logic [CNT_W-1:0]  cmp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mode_q <= '0;
            ioc_q  <= '0;
            ien_q  <= '0;
            cmp_q  <= '0;
        end else if (bus_wr) begin
            if (sel_ctrl) ctrl_q <= bus_wdata[BYTE_W-1:0];
            if (sel_mode) mode_q <= bus_wdata[BYTE_W-1:0];
            if (sel_ioc)  ioc_q  <= bus_wdata[BYTE_W-1:0];
            if (sel_ien)  ien_q  <= bus_wdata[BYTE_W-1:0];
            if (sel_cmp)  cmp_q  <= bus_wdata;
        end
    end

    // Control-field decode
    logic             clr_en;
    logic [SEL_W-1:0] ps_sel;
    assign clr_en = (ctrl_q[6:5] == CLR_CMPA);
    assign ps_sel = ctrl_q[SEL_W-1:0];

    // Run control from the shared start register
    logic running;
    logic start_wr;
    assign start_wr = bus_wr && sel_run;

    pct_run_ctl u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (start_wr),
        .start_val (bus_wdata[RUN_BIT]),
        .running   (running)
    );

    // Prescaler
    logic tick;

    pct_prescaler #(
        .PS_W  (PS_W),
        .SEL_W (SEL_W)
    ) u_ps (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .sel     (ps_sel),
        .tick    (tick)
    );

    // Counter
    logic             cnt_wr;
    logic [CNT_W-1:0] cnt_q;
    logic             match_evt;
    assign cnt_wr = bus_wr && sel_cnt;

    pct_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .clr_en    (clr_en),
        .cmp       (cmp_q),
        .wr_en     (cnt_wr),
        .wr_val    (bus_wdata),
        .cnt       (cnt_q),
        .match_evt (match_evt)
    );

    // Match flag with read-then-clear protocol
    logic flag, armed;

    pct_flag_fsm u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .match_evt (match_evt),
        .stat_rd   (bus_rd && sel_stat),
        .stat_wr   (bus_wr && sel_stat),
        .stat_wbit (bus_wdata[0]),
        .flag      (flag),
        .armed     (armed)
    );

    // Read path
    logic [CNT_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        if (sel_ctrl)      rd_mux = CNT_W'(ctrl_q);
        else if (sel_mode) rd_mux = CNT_W'(mode_q);
        else if (sel_ioc)  rd_mux = CNT_W'(ioc_q);
        else if (sel_ien)  rd_mux = CNT_W'(ien_q);
        else if (sel_stat) rd_mux = CNT_W'(flag);
        else if (sel_cnt)  rd_mux = cnt_q;
        else if (sel_cmp)  rd_mux = cmp_q;
        else if (sel_run)  rd_mux[RUN_BIT] = running;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
        else             bus_rdata <= '0;
    end

    assign irq_out = flag && ien_q[0];

endmodule

// File: rtl/pct_channel_chk.sv
module pct_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             tick,
    input logic             match_evt,
    input logic             clr_en,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] wdata,
    input logic [CNT_W-1:0] cnt,
    input logic             flag,
    input logic             armed,
    input logic             irq_out,
    input logic             ien0
);

    // R3: a stopped counter without a write keeps its value
    p_stopped_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_wr) |=> $stable(cnt));

    // R4: no prescaled tick while the channel is idle
    p_no_tick_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !tick);

    // R5: clear-on-match returns the counter to zero on the matching tick
    p_clear_on_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && clr_en) |=> (cnt == '0));

    // R5: every match leaves the flag set
    p_match_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> flag);

    // R6: the interrupt never rises without its enable
    p_irq_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ien0);

    // R7: a flag software has not read cannot drop
    p_unread_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !armed) |=> flag);

    // R9: a counter write lands exactly
    p_cnt_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(wdata)));

endmodule

bind pct_channel pct_channel_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .running   (running),
    .tick      (tick),
    .match_evt (match_evt),
    .clr_en    (clr_en),
    .cnt_wr    (cnt_wr),
    .wdata     (bus_wdata),
    .cnt       (cnt_q),
    .flag      (flag),
    .armed     (armed),
    .irq_out   (irq_out),
    .ien0      (ien_q[0])
);

// File: tb/pct_channel_bench.sv
module pct_channel_bench;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int NVEC   = 82;

    localparam logic [1:0] OP_WR  = 2'd0;  // write
    localparam logic [1:0] OP_RD  = 2'd1;  // read and compare
    localparam logic [1:0] OP_IDL = 2'd2;  // idle data cycles
    localparam logic [1:0] OP_IRQ = 2'd3;  // compare irq_out

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [15:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        // R1 reset state
        '{OP_RD,  8'h00, 16'h0000, 4'd1},
        '{OP_RD,  8'h06, 16'h0000, 4'd1},
        '{OP_RD,  8'h40, 16'h0000, 4'd1},
        '{OP_IRQ, 8'h00, 16'h0000, 4'd1},
        // R2 register map readback
        '{OP_WR,  8'h00, 16'h0023, 4'd2},
        '{OP_RD,  8'h00, 16'h0023, 4'd2},
        '{OP_WR,  8'h01, 16'h005A, 4'd2},
        '{OP_RD,  8'h01, 16'h005A, 4'd2},
        '{OP_WR,  8'h02, 16'h003C, 4'd2},
        '{OP_RD,  8'h02, 16'h003C, 4'd2},
        '{OP_WR,  8'h04, 16'h0001, 4'd2},
        '{OP_RD,  8'h04, 16'h0001, 4'd2},
        '{OP_WR,  8'h08, 16'h1234, 4'd2},
        '{OP_RD,  8'h08, 16'h1234, 4'd2},
        '{OP_WR,  8'h06, 16'hBEEF, 4'd2},
        '{OP_RD,  8'h06, 16'hBEEF, 4'd2},
        // R3 shared start register isolation
        '{OP_WR,  8'h40, 16'h00FF, 4'd3},
        '{OP_RD,  8'h40, 16'h0004, 4'd3},
        '{OP_WR,  8'h40, 16'h00FB, 4'd3},
        '{OP_RD,  8'h40, 16'h0000, 4'd3},
        '{OP_RD,  8'h06, 16'hBEEF, 4'd3},
        // R5 period with clear-on-match, divide by 1; R10 mode/ioctl left nonzero
        '{OP_WR,  8'h00, 16'h0020, 4'd5},
        '{OP_WR,  8'h08, 16'h0003, 4'd5},
        '{OP_WR,  8'h06, 16'h0000, 4'd5},
        '{OP_WR,  8'h40, 16'h0004, 4'd5},
        '{OP_IDL, 8'h00, 16'h0003, 4'd5},
        '{OP_IRQ, 8'h00, 16'h0000, 4'd5},
        '{OP_IDL, 8'h00, 16'h0001, 4'd5},
        '{OP_IRQ, 8'h00, 16'h0001, 4'd10},
        '{OP_WR,  8'h40, 16'h0000, 4'd5},
        '{OP_RD,  8'h06, 16'h0001, 4'd5},
        // R7 read-then-write clear protocol
        '{OP_WR,  8'h05, 16'h00FE, 4'd7},
        '{OP_IRQ, 8'h00, 16'h0001, 4'd7},
        '{OP_RD,  8'h05, 16'h0001, 4'd7},
        '{OP_WR,  8'h05, 16'h0001, 4'd7},
        '{OP_IRQ, 8'h00, 16'h0001, 4'd7},
        '{OP_WR,  8'h05, 16'h00FE, 4'd7},
        '{OP_IRQ, 8'h00, 16'h0000, 4'd7},
        '{OP_RD,  8'h05, 16'h0000, 4'd7},
        // R4 divide by 4: match on the 8th running cycle, not the 7th
        '{OP_WR,  8'h00, 16'h0021, 4'd4},
        '{OP_WR,  8'h08, 16'h0001, 4'd4},
        '{OP_WR,  8'h06, 16'h0000, 4'd4},
        '{OP_WR,  8'h40, 16'h0004, 4'd4},
        '{OP_IDL, 8'h00, 16'h0007, 4'd4},
        '{OP_IRQ, 8'h00, 16'h0000, 4'd4},
        '{OP_IDL, 8'h00, 16'h0001, 4'd4},
        '{OP_IRQ, 8'h00, 16'h0001, 4'd4},
        '{OP_WR,  8'h40, 16'h0000, 4'd4},
        '{OP_RD,  8'h06, 16'h0000, 4'd4},
        '{OP_RD,  8'h05, 16'h0001, 4'd4},
        '{OP_WR,  8'h05, 16'h00FE, 4'd4},
        // R5 no-clear mode keeps counting; R6 enable gates the interrupt
        '{OP_WR,  8'h00, 16'h0000, 4'd5},
        '{OP_WR,  8'h08, 16'h0002, 4'd5},
        '{OP_WR,  8'h06, 16'h0000, 4'd5},
        '{OP_WR,  8'h04, 16'h0000, 4'd6},
        '{OP_WR,  8'h40, 16'h0004, 4'd5},
        '{OP_IDL, 8'h00, 16'h0003, 4'd5},
        '{OP_WR,  8'h40, 16'h0000, 4'd5},
        '{OP_IRQ, 8'h00, 16'h0000, 4'd6},
        '{OP_RD,  8'h05, 16'h0001, 4'd6},
        '{OP_RD,  8'h06, 16'h0004, 4'd5},
        '{OP_WR,  8'h04, 16'h0001, 4'd6},
        '{OP_IRQ, 8'h00, 16'h0001, 4'd6},
        // R8 clear write in the match cycle: set wins, arming is lost
        '{OP_WR,  8'h00, 16'h0020, 4'd8},
        '{OP_WR,  8'h08, 16'h0003, 4'd8},
        '{OP_WR,  8'h06, 16'h0000, 4'd8},
        '{OP_WR,  8'h40, 16'h0004, 4'd8},
        '{OP_IDL, 8'h00, 16'h0003, 4'd8},
        '{OP_WR,  8'h05, 16'h00FE, 4'd8},
        '{OP_WR,  8'h40, 16'h0000, 4'd8},
        '{OP_IRQ, 8'h00, 16'h0001, 4'd8},
        '{OP_WR,  8'h05, 16'h00FE, 4'd8},
        '{OP_IRQ, 8'h00, 16'h0001, 4'd8},
        '{OP_RD,  8'h05, 16'h0001, 4'd8},
        '{OP_WR,  8'h05, 16'h00FE, 4'd8},
        '{OP_IRQ, 8'h00, 16'h0000, 4'd8},
        // R9 counter write beats a concurrent tick
        '{OP_WR,  8'h08, 16'h1234, 4'd9},
        '{OP_WR,  8'h06, 16'h0000, 4'd9},
        '{OP_WR,  8'h40, 16'h0004, 4'd9},
        '{OP_WR,  8'h06, 16'h0100, 4'd9},
        '{OP_WR,  8'h40, 16'h0000, 4'd9},
        '{OP_RD,  8'h06, 16'h0101, 4'd9}
    };

    logic              clk;
    logic              rst_n;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_wr;
    logic              bus_rd;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq_out;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    pct_channel u_pct_channel (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic do_wr(input logic [7:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, input logic [15:0] exp, input int req);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        n_chk++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL R%0d read @%02h: actual %04h expected %04h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input int req);
        n_chk++;
        if (irq_out !== exp) begin
            n_fail++;
            $display("FAIL R%0d irq_out: actual %0b expected %0b", req, irq_out, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst_n     = 1'b0;
        bus_addr  = '0;
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
        bus_wdata = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        for (int i = 0; i < NVEC; i++) begin
            unique case (VECS[i].op)
                OP_WR:  do_wr(VECS[i].addr, VECS[i].data);
                OP_RD:  do_rd(VECS[i].addr, VECS[i].data, int'(VECS[i].req));
                OP_IDL: idle(int'(VECS[i].data));
                OP_IRQ: chk_irq(VECS[i].data[0], int'(VECS[i].req));
                default: ;
            endcase
        end

        // R4 divide by 16: compare 0 matches on the 16th running cycle
        do_wr(8'h04, 16'h0001);
        do_wr(8'h00, 16'h0022);
        do_wr(8'h08, 16'h0000);
        do_wr(8'h06, 16'h0000);
        do_wr(8'h40, 16'h0004);
        idle(15);
        chk_irq(1'b0, 4);
        idle(1);
        chk_irq(1'b1, 4);

        // R1 reset in the middle of a running, flagged channel
        rst_n = 1'b0;
        idle(2);
        chk_irq(1'b0, 1);
        rst_n = 1'b1;
        idle(1);
        do_rd(8'h00, 16'h0000, 1);
        do_rd(8'h04, 16'h0000, 1);
        do_rd(8'h05, 16'h0000, 1);
        do_rd(8'h40, 16'h0000, 1);
        do_rd(8'h08, 16'h0000, 1);
        idle(4);
        do_rd(8'h06, 16'h0000, 1);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule